// File: doc/BRIEF.md
# Serial Unlock Access Controller for a Time Register File

This block lets a host reach a set of BCD time registers through nothing but ordinary memory cycles. It sits beside a parallel memory and watches write cycles that fall inside the memory block. On those cycles it reads data bit 0 and compares the bits against a fixed 64-bit unlock key. Writes that carry any other pattern do not affect the time registers.

When the last key bit matches, the block opens a transfer window of 64 qualifying bus cycles. In this window each cycle moves one bit of the eight 8-bit time registers over data bit 0. Bit 0 of register 0 goes first and bit 7 of register 7 goes last. A write cycle shifts a bit in. A read cycle drives a bit out.

Reads come from a snapshot of all registers, taken when the key completes. A register is committed to the register file only when all eight of its cycles were writes. After the 64th cycle the block goes back to hunting for the key.

Top module: `phc_serial_ctl`

## Requirements
- R1: A qualifying write cycle is a clock with ce_n=0, in_block=1 and we_n=0. The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, each sent least significant bit first on dq0_in in qualifying write cycles. A match on the 64th bit opens the transfer window from the next clock.
- R2: A key bit that does not match restarts matching. That same bit is then judged as key bit 0, so after a mismatching 1 the next expected bit is key bit 1. A key with any bit wrong does not open the window.
- R3: Clocks with ce_n=1 or in_block=0 are ignored. They break neither a partly received key nor an open transfer window.
- R4: The window spans exactly 64 qualifying cycles (write or read). Window cycle k addresses register k/8, bit k%8, which is rf_rdata bit k.
- R5: A write cycle in the window receives dq0_in. On the cycle that carries bit 7 of a register whose 8 cycles were all writes, the block commits the register. rf_we is high for exactly the following clock, with rf_widx equal to the register number and rf_wdata equal to the assembled byte.
- R6: A register whose 8 window cycles include any read cycle is not committed, so its stored value is unchanged.
- R7: A read cycle (ce_n=0, in_block=1, we_n=1, oe_n=0) in the window raises dq0_oe during that clock and presents the addressed snapshot bit on dq0_out.
- R8: The snapshot is taken from rf_rdata at the clock edge where the key completes. Changes to rf_rdata later in the window are not seen by reads.
- R9: A qualifying cycle with both we_n=0 and oe_n=0 is a write cycle. dq0_oe stays low in that cycle.
- R10: After the 64th window cycle the block is hunting again. Read cycles while hunting leave dq0_oe low, and key bits are matched from bit 0.
- R11: After reset the block is hunting, dq0_oe is low and rf_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| in_block | input | 1 | High when the cycle's address lies in the memory block |
| dq0_in | input | 1 | Data bit 0 from the bus |
| dq0_out | output | 1 | Data bit 0 driven in read transfer cycles |
| dq0_oe | output | 1 | Drive enable for dq0_out |
| rf_rdata | input | 64 | Time register file contents, register r at bits 8r+7..8r |
| rf_we | output | 1 | One-clock commit strobe for a whole register |
| rf_widx | output | 3 | Register number being committed |
| rf_wdata | output | 8 | Byte being committed |

## Verification
Two events meet on the last write of a window: the commit of register 7 and the return to key hunting fall on the same clock edge. The bench provokes this by writing all 64 bits. It checks that the register 7 commit still arrives, and that a read on the very next clock finds dq0_oe low. A scoreboard queue holds every commit the requirements predict. The commit monitor pops each strobe against that queue, so a missing, extra or wrongly indexed commit around the window edge is reported.

// File: rtl/phc_pkg.sv
package phc_pkg;
   // 64-bit unlock key, byte 0 in bits 7:0, each byte sent LSB first
   localparam int unsigned    UNLOCK_W   = 64;
   localparam logic [63:0]    UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;
   typedef enum logic [1:0] {CYC_NONE, CYC_WR, CYC_RD} cyc_e;
endpackage

// File: rtl/phc_key_match.sv
module phc_key_match #(
   parameter int unsigned       KEY_W = 64,
   parameter logic [KEY_W-1:0]  KEY   = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic wr,
   input  logic din,
   output logic hit
);
   localparam int unsigned CW = $clog2(KEY_W);

   if (KEY_W < 2) begin : g_bad_len
      $error("phc_key_match: KEY_W must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          bit_ok;
   logic          at_last;

   always_comb begin
      bit_ok  = (din == KEY[cnt]);
      at_last = (cnt == CW'(KEY_W - 1));
      hit     = arm && wr && bit_ok && at_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!arm) begin
         cnt <= '0;
      end else if (wr) begin
         if (hit)         cnt <= '0;
         else if (bit_ok) cnt <= cnt + CW'(1);
         else             cnt <= (din == KEY[0]) ? CW'(1) : '0;
      end
   end

   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && wr && !bit_ok) |=> (cnt < CW'(2)));
endmodule

// File: rtl/phc_xfer.sv
module phc_xfer #(
   parameter int unsigned NREG     = 8,
   parameter int unsigned RBW      = 8,
   parameter bit          SNAPSHOT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    wr,
   input  logic                    rd,
   input  logic                    din,
   input  logic [NREG*RBW-1:0]     rf_rdata,
   output logic                    active,
   output logic                    dq0_out,
   output logic                    dq0_oe,
   output logic                    rf_we,
   output logic [$clog2(NREG)-1:0] rf_widx,
   output logic [RBW-1:0]          rf_wdata
);
   localparam int unsigned TOT = NREG * RBW;
   localparam int unsigned IW  = $clog2(TOT);
   localparam int unsigned BW  = $clog2(RBW);
   localparam int unsigned RW  = $clog2(NREG);

   if ((RBW < 2) || ((RBW & (RBW - 1)) != 0)) begin : g_bad_rbw
      $error("phc_xfer: RBW must be a power of two of at least 2");
   end
   if ((NREG < 2) || ((NREG & (NREG - 1)) != 0)) begin : g_bad_nreg
      $error("phc_xfer: NREG must be a power of two of at least 2");
   end

   logic [IW-1:0]  idx;
   logic [RBW-1:0] asm_q;
   logic           clean;
   logic [TOT-1:0] img;
   logic [BW-1:0]  bpos;
   logic           reg_end;
   logic           win_end;
   logic [RBW-1:0] byte_nx;

   if (SNAPSHOT) begin : g_snap
      logic [TOT-1:0] snap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     snap_q <= '0;
         else if (start) snap_q <= rf_rdata;
      end
      assign img = snap_q;

      assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         active |=> $stable(snap_q));
   end else begin : g_live
      assign img = rf_rdata;
   end

   always_comb begin
      bpos          = idx[BW-1:0];
      reg_end       = (bpos == BW'(RBW - 1));
      win_end       = (idx == IW'(TOT - 1));
      byte_nx       = asm_q;
      byte_nx[bpos] = din;
      dq0_oe        = active && rd;
      dq0_out       = dq0_oe && img[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         idx      <= '0;
         asm_q    <= '0;
         clean    <= 1'b1;
         rf_we    <= 1'b0;
         rf_widx  <= '0;
         rf_wdata <= '0;
      end else begin
         rf_we <= 1'b0;
         if (start) begin
            active <= 1'b1;
            idx    <= '0;
            clean  <= 1'b1;
         end else if (active && (wr || rd)) begin
            if (wr) asm_q <= byte_nx;
            if (reg_end) begin
               if (clean && wr) begin
                  rf_we    <= 1'b1;
                  rf_widx  <= idx[IW-1:BW];
                  rf_wdata <= byte_nx;
               end
               clean <= 1'b1;
            end else begin
               clean <= clean && wr;
            end
            idx <= idx + IW'(1);
            if (win_end) active <= 1'b0;
         end
      end
   end

   assert_commit_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(active && wr));
   assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);
endmodule

// File: rtl/phc_serial_ctl.sv
module phc_serial_ctl #(
   parameter int unsigned NREG     = 8,
   parameter int unsigned RBW      = 8,
   parameter bit          SNAPSHOT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_n,
   input  logic                    oe_n,
   input  logic                    we_n,
   input  logic                    in_block,
   input  logic                    dq0_in,
   output logic                    dq0_out,
   output logic                    dq0_oe,
   input  logic [NREG*RBW-1:0]     rf_rdata,
   output logic                    rf_we,
   output logic [$clog2(NREG)-1:0] rf_widx,
   output logic [RBW-1:0]          rf_wdata
);
   import phc_pkg::*;

   phc_pkg::cyc_e cyc;
   logic bus_wr, bus_rd, key_hit, xfer_on;

   always_comb begin
      cyc = CYC_NONE;
      if (!ce_n && in_block) begin
         if (!we_n)      cyc = CYC_WR;
         else if (!oe_n) cyc = CYC_RD;
      end
      bus_wr = (cyc == CYC_WR);
      bus_rd = (cyc == CYC_RD);
   end

   phc_key_match #(
      .KEY_W (UNLOCK_W),
      .KEY   (UNLOCK_KEY)
   ) u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (!xfer_on),
      .wr    (bus_wr),
      .din   (dq0_in),
      .hit   (key_hit)
   );

   phc_xfer #(
      .NREG     (NREG),
      .RBW      (RBW),
      .SNAPSHOT (SNAPSHOT)
   ) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (key_hit),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .din      (dq0_in),
      .rf_rdata (rf_rdata),
      .active   (xfer_on),
      .dq0_out  (dq0_out),
      .dq0_oe   (dq0_oe),
      .rf_we    (rf_we),
      .rf_widx  (rf_widx),
      .rf_wdata (rf_wdata)
   );

   assert_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> xfer_on);
   assert_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_on) |-> $past(bus_wr || bus_rd));
   assert_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n) |-> !dq0_oe);
endmodule

// File: tb/phc_serial_ctl_test.sv
module phc_serial_ctl_test;
   localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, in_block = 1'b0, dq0_in = 1'b0;
   logic dq0_out, dq0_oe, rf_we;
   logic [2:0] rf_widx;
   logic [7:0] rf_wdata;
   logic [7:0] regs [8];
   logic [63:0] rf_flat;
   logic [10:0] expq [$];
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   always_comb for (int r = 0; r < 8; r++) rf_flat[r*8 +: 8] = regs[r];

   phc_serial_ctl uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .in_block(in_block), .dq0_in(dq0_in), .dq0_out(dq0_out), .dq0_oe(dq0_oe),
      .rf_rdata(rf_flat), .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // commit monitor: pops the scoreboard and updates the register file model
   always @(negedge clk) begin
      if (rst_n && rf_we) begin
         n_chk++;
         if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL R5/R6: actual commit %0h expected none", {rf_widx, rf_wdata});
         end else begin
            logic [10:0] e;
            e = expq.pop_front();
            if ({rf_widx, rf_wdata} !== e) begin
               n_bad++;
               $display("FAIL R5: actual %0h expected %0h", {rf_widx, rf_wdata}, e);
            end
         end
         regs[rf_widx] = rf_wdata;
      end
   end

   task automatic bus(input logic ce, we, oe, blk, d, output logic g_oe, output logic g_d);
      @(negedge clk);
      ce_n = ce; we_n = we; oe_n = oe; in_block = blk; dq0_in = d;
      #5;
      g_oe = dq0_oe; g_d = dq0_out;
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; in_block = 1'b0;
   endtask

   task automatic wbit(input logic d);
      logic a, b;
      bus(1'b0, 1'b0, 1'b1, 1'b1, d, a, b);
   endtask

   task automatic noise(input logic d);
      logic a, b;
      bus(1'b0, 1'b0, 1'b1, 1'b0, d, a, b);   // out of block
      bus(1'b1, 1'b0, 1'b0, 1'b1, d, a, b);   // chip not enabled
   endtask

   task automatic rbit(output logic g_oe, output logic g_d);
      bus(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, g_oe, g_d);
   endtask

   task automatic send_key(input bit with_noise);
      for (int i = 0; i < 64; i++) begin
         if (with_noise && (i % 8 == 3)) noise(~KEY[i]);
         wbit(KEY[i]);
      end
   endtask

   task automatic do_reset();
      idle();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic g_oe, g_d;
      logic [63:0] v1, snap;
      regs = '{8'h00, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h45};
      v1 = 64'h98_12_28_06_15_37_42_01;
      repeat (3) @(negedge clk);
      check(dq0_oe == 1'b0, "R11 oe in reset", dq0_oe, 0);
      check(rf_we == 1'b0, "R11 we in reset", rf_we, 0);
      rst_n = 1'b1;

      rbit(g_oe, g_d);
      check(g_oe == 1'b0, "R10 read while hunting", g_oe, 0);

      // full write window with noise in the key; last write ends the window
      send_key(1'b1);
      for (int k = 0; k < 64; k++) begin
         if (k % 8 == 7) expq.push_back({3'(k / 8), v1[(k/8)*8 +: 8]});
         if (k == 20) noise(~v1[k]);                // R3 inside window
         wbit(v1[k]);
      end
      rbit(g_oe, g_d);
      check(g_oe == 1'b0, "R10 read right after window", g_oe, 0);
      idle(); idle();
      check(expq.size() == 0, "R5 all commits seen", expq.size(), 0);
      check(rf_flat == v1, "R1 R4 R5 stored image", rf_flat, v1);

      // corrupted key must not open a window
      do_reset();
      for (int i = 0; i < 64; i++) wbit(i == 40 ? ~KEY[i] : KEY[i]);
      rbit(g_oe, g_d);
      check(g_oe == 1'b0, "R2 broken key stays locked", g_oe, 0);

      // mismatching 1 is rechecked as key bit 0
      do_reset();
      for (int i = 0; i < 3; i++) wbit(KEY[i]);
      wbit(1'b1);
      for (int i = 1; i < 64; i++) wbit(KEY[i]);
      snap = rf_flat;
      for (int k = 0; k < 64; k++) begin
         if (k == 10) regs[3] = ~regs[3];          // R8 change after snapshot
         if (k == 30) noise(1'b1);                 // R3 inside read window
         rbit(g_oe, g_d);
         check(g_oe == 1'b1, "R7 oe in read window", g_oe, 1);
         check(g_d == snap[k], "R4 R7 R8 read bit", g_d, snap[k]);
      end
      rbit(g_oe, g_d);
      check(g_oe == 1'b0, "R10 hunting after 64 reads", g_oe, 0);

      // mixed register 0 is dropped, register 1 written with both strobes low
      idle();
      send_key(1'b0);
      snap = rf_flat;
      for (int k = 0; k < 4; k++) wbit(1'b1);
      for (int k = 4; k < 8; k++) begin
         rbit(g_oe, g_d);
         check(g_d == snap[k], "R6 read in mixed byte", g_d, snap[k]);
      end
      expq.push_back({3'd1, 8'h36});
      for (int k = 0; k < 8; k++) begin
         logic d;
         d = 1'((8'h36 >> k) & 8'h01);
         bus(1'b0, 1'b0, 1'b0, 1'b1, d, g_oe, g_d);
         check(g_oe == 1'b0, "R9 no drive on both strobes", g_oe, 0);
      end
      for (int k = 16; k < 64; k++) begin
         rbit(g_oe, g_d);
         check(g_d == snap[k], "R7 read after write", g_d, snap[k]);
      end
      idle(); idle();
      check(regs[0] == snap[7:0], "R6 mixed byte not committed", regs[0], snap[7:0]);
      check(regs[1] == 8'h36, "R9 both-low cycles wrote", regs[1], 8'h36);
      check(expq.size() == 0, "R5 R6 commit count", expq.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule